// File: doc/BRIEF.md
# RTC Offset Trim Unit

This unit sits between the 32.768 kHz oscillator of a real-time clock and its seconds prescaler. It trims the average length of a second without touching the oscillator. Within each correction period it adds extra tick pulses to the prescaler stream, or withholds real ones, so that the prescaler counts a second slightly early or slightly late. An 8-bit trim register chooses the correction period and a signed correction count. An interrupt line gives one pulse for every correction applied, provided correction interrupts are enabled.

The oscillator arrives as a level on `osc_i` and is resynchronised to the system clock. Each rising oscillator edge normally gives a one-cycle pulse on `tick_o`. For a positive trim value N, the first N seconds of every correction period each receive one extra pulse, placed in the low half of an oscillator period. For a negative value, the first real tick of each of the first N seconds is dropped. A register write goes into a holding copy. That copy becomes active only at the next correction period boundary.

Top module: `rtc_offset_trim`

## Requirements
- R1: While reset is asserted and right after it, `tick_o` and `irq_o` are low. The active trim is zero and normal mode is selected, so the first period passes every oscillator tick unchanged.
- R2: Trim register encoding: bit 7 selects the period (0 = normal, 1 = fast). Bits 6:0 are a two's-complement correction count from -64 (1000000) to +63 (0111111); 1111111 means -1.
- R3: A positive count N adds exactly N tick pulses per correction period, one in each of the first N seconds.
- R4: A negative count -N removes exactly N tick pulses per correction period: the first real tick in each of the first N seconds is suppressed.
- R5: A second is SEC_TICKS oscillator ticks. A correction period is NORM_SECS seconds in normal mode and FAST_SECS seconds in fast mode. The stream over one period therefore holds SEC_TICKS times the period length plus the signed count.
- R6: A write reaches only the holding copy. It takes effect at the next correction period boundary and never alters the period in progress. When several writes fall in one period, the last one applies.
- R7: Every `tick_o` pulse lasts one clock cycle. An added pulse is emitted in the low half of an oscillator period, so it never merges with a real tick.
- R8: With `irq_en_i` high, `irq_o` gives one pulse per correction applied. With it low, no pulse is given.
- R9: An interrupt pulse lasts NORM_INT_TICKS oscillator periods in normal mode and FAST_INT_TICKS oscillator periods in fast mode, per the mode active in that period.
- R10: The extreme counts +63 and -64 apply 63 and 64 corrections per period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, much faster than the oscillator |
| rst_ni | input | 1 | Asynchronous reset, active low |
| osc_i | input | 1 | 32.768 kHz oscillator level |
| wr_en_i | input | 1 | Trim register write strobe |
| wr_data_i | input | 8 | Trim register write value |
| irq_en_i | input | 1 | Correction interrupt enable |
| tick_o | output | 1 | Corrected tick pulses to the seconds prescaler |
| irq_o | output | 1 | Correction interrupt pulse |

## Verification
The assertions assume that each oscillator level lasts at least three system clocks. This keeps edges, second boundaries and correction events in separate cycles. They also assume that writes and enable changes do not land in a second where a correction is pending. The stimulus drives the oscillator with four clocks per half period. It makes every register write and enable change after second 66 of a period, where no correction remains. Each period is scored as a whole: total pulses, interrupt count and each interrupt's width, all derived from the value held at that period's boundary.

// File: rtl/rtc_trim_pkg.sv
package rtc_trim_pkg;

  typedef enum logic {
    TRIM_NORMAL = 1'b0,
    TRIM_FAST   = 1'b1
  } trim_mode_e;

  typedef struct packed {
    trim_mode_e mode;
    logic [6:0] val;
  } trim_cfg_t;

  function automatic logic [6:0] trim_mag(input logic [6:0] v);
    return v[6] ? (~v + 7'd1) : v;
  endfunction

endpackage

// File: rtl/rtc_trim_edge.sv
module rtc_trim_edge #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic osc_i,
  output logic lvl_o,
  output logic rise_o,
  output logic fall_o
);

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   lvl_q;

  generate
    if (SYNC_STAGES == 1) begin : g_single
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sync_q <= '0;
        else         sync_q <= osc_i;
      end
    end else begin : g_chain
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sync_q <= '0;
        else         sync_q <= {sync_q[SYNC_STAGES-2:0], osc_i};
      end
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) lvl_q <= 1'b0;
    else         lvl_q <= sync_q[SYNC_STAGES-1];
  end

  assign lvl_o  = sync_q[SYNC_STAGES-1];
  assign rise_o = lvl_o & ~lvl_q;
  assign fall_o = ~lvl_o & lvl_q;

endmodule

// File: rtl/rtc_trim_regs.sv
module rtc_trim_regs
  import rtc_trim_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      wr_en_i,
  input  logic [7:0] wr_data_i,
  input  logic      cyc_bound_i,
  output trim_cfg_t active_o
);

  trim_cfg_t hold_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      hold_q <= '0;
    else if (wr_en_i) hold_q <= trim_cfg_t'(wr_data_i);
  end

  // holding copy goes live only on a period boundary
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          active_o <= '0;
    else if (cyc_bound_i) active_o <= hold_q;
  end

endmodule

// File: rtl/rtc_trim_timebase.sv
module rtc_trim_timebase
  import rtc_trim_pkg::*;
#(
  parameter int SEC_TICKS = 32768,
  parameter int NORM_SECS = 7200,
  parameter int FAST_SECS = 240,
  parameter int SCW       = 13
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           rise_i,
  input  trim_mode_e     mode_i,
  output logic           sec_bound_o,
  output logic           cyc_bound_o,
  output logic [SCW-1:0] sec_idx_o
);

  localparam int TCW = (SEC_TICKS > 1) ? $clog2(SEC_TICKS) : 1;
  localparam logic [TCW-1:0] TICK_LAST = TCW'(SEC_TICKS - 1);
  localparam logic [SCW-1:0] NORM_LAST = SCW'(NORM_SECS - 1);
  localparam logic [SCW-1:0] FAST_LAST = SCW'(FAST_SECS - 1);

  logic [TCW-1:0] tick_cnt_q;
  logic [SCW-1:0] sec_cnt_q;
  logic [SCW-1:0] sec_last;

  assign sec_last    = (mode_i == TRIM_FAST) ? FAST_LAST : NORM_LAST;
  assign sec_bound_o = rise_i && (tick_cnt_q == TICK_LAST);
  assign cyc_bound_o = sec_bound_o && (sec_cnt_q == sec_last);
  assign sec_idx_o   = sec_cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tick_cnt_q <= '0;
    end else if (rise_i) begin
      tick_cnt_q <= (tick_cnt_q == TICK_LAST) ? '0 : tick_cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sec_cnt_q <= '0;
    end else if (sec_bound_o) begin
      sec_cnt_q <= cyc_bound_o ? '0 : sec_cnt_q + 1'b1;
    end
  end

endmodule

// File: rtl/rtc_trim_corr.sv
module rtc_trim_corr
  import rtc_trim_pkg::*;
#(
  parameter int NORM_INT_TICKS = 16,
  parameter int FAST_INT_TICKS = 8,
  parameter int SCW            = 13
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           rise_i,
  input  logic           fall_i,
  input  logic           sec_bound_i,
  input  logic [SCW-1:0] sec_idx_i,
  input  trim_cfg_t      cfg_i,
  input  logic           irq_en_i,
  output logic           ins_o,
  output logic           drop_o,
  output logic           irq_o
);

  localparam int MAXW = (NORM_INT_TICKS > FAST_INT_TICKS) ? NORM_INT_TICKS : FAST_INT_TICKS;
  localparam int ICW  = $clog2(2 * MAXW + 1);
  localparam int MW   = (SCW > 7) ? SCW : 7;
  localparam logic [ICW-1:0] NORM_HALVES = ICW'(2 * NORM_INT_TICKS);
  localparam logic [ICW-1:0] FAST_HALVES = ICW'(2 * FAST_INT_TICKS);

  logic [6:0]     mag;
  logic           neg;
  logic           sec_bound_q;
  logic           pending_q;
  logic           evt;
  logic [ICW-1:0] halves_ld;
  logic [ICW-1:0] halves_q;

  assign mag    = trim_mag(cfg_i.val);
  assign neg    = cfg_i.val[6];
  assign ins_o  = pending_q & ~neg & fall_i;
  assign drop_o = pending_q & neg & rise_i;
  assign evt    = ins_o | drop_o;

  // evaluated one cycle after the boundary so the new active value is seen
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sec_bound_q <= 1'b0;
      pending_q   <= 1'b0;
    end else begin
      sec_bound_q <= sec_bound_i;
      if (sec_bound_q)  pending_q <= (MW'(sec_idx_i) < MW'(mag));
      else if (evt)     pending_q <= 1'b0;
    end
  end

  assign halves_ld = (cfg_i.mode == TRIM_FAST) ? FAST_HALVES : NORM_HALVES;

  // width counted on both oscillator edges: exact whatever edge triggered it
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      irq_o    <= 1'b0;
      halves_q <= '0;
    end else if (evt && irq_en_i) begin
      irq_o    <= 1'b1;
      halves_q <= halves_ld;
    end else if ((rise_i || fall_i) && (halves_q != '0)) begin
      halves_q <= halves_q - 1'b1;
      if (halves_q == ICW'(1)) irq_o <= 1'b0;
    end
  end

  AST_CORR_IN_WINDOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ins_o || drop_o) |-> (MW'(sec_idx_i) < MW'(mag))); // R3
  AST_IRQ_NEEDS_EN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_o) |-> $past(irq_en_i)); // R8
  AST_IRQ_FROM_CORR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_o) |-> $past(ins_o || drop_o)); // R8

endmodule

// File: rtl/rtc_offset_trim.sv
module rtc_offset_trim
  import rtc_trim_pkg::*;
#(
  parameter int SEC_TICKS      = 32768,
  parameter int NORM_SECS      = 7200,
  parameter int FAST_SECS      = 240,
  parameter int NORM_INT_TICKS = 16,
  parameter int FAST_INT_TICKS = 8,
  parameter int SYNC_STAGES    = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       osc_i,
  input  logic       wr_en_i,
  input  logic [7:0] wr_data_i,
  input  logic       irq_en_i,
  output logic       tick_o,
  output logic       irq_o
);

  localparam int MAX_SECS = (NORM_SECS > FAST_SECS) ? NORM_SECS : FAST_SECS;
  localparam int SCW      = $clog2(MAX_SECS);

  logic           osc_lvl;
  logic           rise;
  logic           fall;
  logic           sec_bound;
  logic           cyc_bound;
  logic [SCW-1:0] sec_idx;
  trim_cfg_t      active;
  logic           ins;
  logic           drop;
  logic           tick_q;

  rtc_trim_edge #(
    .SYNC_STAGES(SYNC_STAGES)
  ) u_edge (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .osc_i  (osc_i),
    .lvl_o  (osc_lvl),
    .rise_o (rise),
    .fall_o (fall)
  );

  rtc_trim_timebase #(
    .SEC_TICKS (SEC_TICKS),
    .NORM_SECS (NORM_SECS),
    .FAST_SECS (FAST_SECS),
    .SCW       (SCW)
  ) u_timebase (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .rise_i      (rise),
    .mode_i      (active.mode),
    .sec_bound_o (sec_bound),
    .cyc_bound_o (cyc_bound),
    .sec_idx_o   (sec_idx)
  );

  rtc_trim_regs u_regs (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .wr_en_i     (wr_en_i),
    .wr_data_i   (wr_data_i),
    .cyc_bound_i (cyc_bound),
    .active_o    (active)
  );

  rtc_trim_corr #(
    .NORM_INT_TICKS (NORM_INT_TICKS),
    .FAST_INT_TICKS (FAST_INT_TICKS),
    .SCW            (SCW)
  ) u_corr (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .rise_i      (rise),
    .fall_i      (fall),
    .sec_bound_i (sec_bound),
    .sec_idx_i   (sec_idx),
    .cfg_i       (active),
    .irq_en_i    (irq_en_i),
    .ins_o       (ins),
    .drop_o      (drop),
    .irq_o       (irq_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) tick_q <= 1'b0;
    else         tick_q <= (rise & ~drop) | ins;
  end

  assign tick_o = tick_q;

  AST_TICK_SPLIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o |=> !tick_o); // R7
  AST_INSERT_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ins |-> !osc_lvl); // R7
  AST_DROP_SILENT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    drop |=> !tick_o); // R4

endmodule

// File: tb/tb_rtc_offset_trim.sv
module tb_rtc_offset_trim;

  localparam int TPS = 4;
  localparam int NS  = 100;
  localparam int FS  = 80;
  localparam int NW  = 3;
  localparam int FW  = 1;
  localparam int HP  = 4;  // clocks per oscillator half period

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       osc = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic       irq_en = 1'b0;
  logic       tick;
  logic       irq;

  always #2 clk = ~clk;

  rtc_offset_trim #(
    .SEC_TICKS      (TPS),
    .NORM_SECS      (NS),
    .FAST_SECS      (FS),
    .NORM_INT_TICKS (NW),
    .FAST_INT_TICKS (FW),
    .SYNC_STAGES    (2)
  ) dut (
    .clk_i     (clk),
    .rst_ni    (rst_n),
    .osc_i     (osc),
    .wr_en_i   (wr_en),
    .wr_data_i (wr_data),
    .irq_en_i  (irq_en),
    .tick_o    (tick),
    .irq_o     (irq)
  );

  typedef struct {
    int ticks;
    int ints;
    int width;
    int val;
    int fast;
  } exp_t;

  exp_t q[$];
  exp_t e;

  int n_chk = 0, n_bad = 0;
  logic [7:0] hold_m = 8'h00;
  int ph = 0, tcnt = 0, scnt = 0, cyc_seen = 0;
  bit act_fast = 0, close_pend = 0, run = 0;
  int tick_n = 0, int_n = 0, hl = 0, wbad = 0, merge = 0;
  logic tick_p = 1'b0, irq_p = 1'b0;

  function automatic int sval(logic [7:0] d);
    return d[6] ? int'(d[6:0]) - 128 : int'(d[6:0]);
  endfunction

  function automatic exp_t mk(logic [7:0] d, logic en);
    exp_t x;
    x.fast  = int'(d[7]);
    x.val   = sval(d);
    x.ticks = TPS * (d[7] ? FS : NS) + x.val;
    x.ints  = en ? ((x.val < 0) ? -x.val : x.val) : 0;
    x.width = 2 * HP * (d[7] ? FW : NW);
    return x;
  endfunction

  function automatic string tag(int v);
    if (v == 63 || v == -64) return "R10";
    if (v > 0) return "R3";
    if (v < 0) return "R4";
    return "R5";
  endfunction

  task automatic check(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // monitor first, then oscillator driver and reference model
  always @(negedge clk) begin
    if (run) begin
      if (tick) begin
        if (tick_p) merge++;
        else        tick_n++;
      end
      if (irq && !irq_p) begin
        int_n++;
        hl = 1;
      end else if (irq) begin
        hl++;
      end
      if (!irq && irq_p && q.size() > 0 && hl != q[0].width) wbad++;
      tick_p = tick;
      irq_p  = irq;

      if (ph == 5 && close_pend) begin
        close_pend = 0;
        e = q.pop_front();
        check($sformatf("%s R2 R6 ticks val=%0d fast=%0d", tag(e.val), e.val, e.fast),
              tick_n, e.ticks);
        check("R7 merged pulses", merge, 0);
        check($sformatf("R8 irq count val=%0d", e.val), int_n, e.ints);
        check($sformatf("R9 irq width mismatches (width %0d)", e.width), wbad, 0);
        tick_n = 0; int_n = 0; wbad = 0; merge = 0;
      end

      osc = (ph < HP);
      if (ph == 0) begin
        tcnt++;
        if (tcnt == TPS) begin
          tcnt = 0;
          scnt++;
          if (scnt == (act_fast ? FS : NS)) begin
            scnt = 0;
            cyc_seen++;
            act_fast = hold_m[7];
            q.push_back(mk(hold_m, irq_en));
            close_pend = 1;
          end
        end
      end
      ph = (ph + 1) % (2 * HP);
    end
  end

  task automatic wr(logic [7:0] d);
    @(negedge clk);
    wr_en   = 1'b1;
    wr_data = d;
    @(negedge clk);
    wr_en   = 1'b0;
    hold_m  = d;
  endtask

  task automatic wait_tail(int k);
    while (!(cyc_seen == k && scnt == 66)) @(negedge clk);
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    check("R1 tick_o in reset", int'(tick), 0);
    check("R1 irq_o in reset", int'(irq), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 tick_o after reset", int'(tick), 0);
    check("R1 irq_o after reset", int'(irq), 0);
    q.push_back(mk(8'h00, 1'b0));
    run = 1;

    wait_tail(0);
    wr(8'h11);          // overwritten before the boundary
    wr(8'h85);          // fast, +5
    irq_en = 1'b1;
    wait_tail(1);
    wr(8'hFD);          // fast, -3
    wait_tail(2);
    wr(8'hBF);          // fast, +63
    wait_tail(3);
    wr(8'hC0);          // fast, -64
    wait_tail(4);
    wr(8'h7F);          // normal, -1
    irq_en = 1'b0;
    wait_tail(5);
    wr(8'h02);          // normal, +2
    irq_en = 1'b1;
    wait_tail(6);
    wr(8'h00);
    while (cyc_seen != 8) @(negedge clk);
    repeat (12) @(negedge clk);
    check("R6 all periods scored", q.size(), 1);
    summary();
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

endmodule